// File: doc/BRIEF.md
# Iterative Signed/Unsigned Integer Divider

This unit performs a multi-cycle integer division for a simple processor pipeline. A one-cycle start strobe supplies a dividend, a divisor, an unsigned-mode select and an exception-enable bit. The unit computes the quotient with a radix-2 restoring shift-subtract loop on operand magnitudes. In signed mode it applies the sign correction at the end, so the quotient truncates toward zero (-7 / 2 gives -3).

There are two fault cases. A zero divisor is detected in the accept cycle, and the unit finishes at the next edge with a quotient of 0. The signed case of the most negative value divided by -1 runs the full latency and returns the most negative value. Both faults set a sticky fault flag, which is cleared only by a dedicated clear input. When exceptions are enabled, a fault also raises an exception request and holds the write enable low, so the pipeline keeps the old destination value. Register writeback, stall logic and exception vectoring belong to the surrounding pipeline.

The control state machine has four states:
- `ST_IDLE` is the rest state and accepts a start. It moves to `ST_ITER` when a start arrives with a non-zero divisor. On a zero divisor it stays in `ST_IDLE` and finishes at once.
- `ST_ITER` runs one quotient bit per cycle. After the last of the WIDTH steps it moves to `ST_PAD` when `AREA_OPT` is 1, or to `ST_FIXUP` otherwise.
- `ST_PAD` always moves to `ST_FIXUP`.
- `ST_FIXUP` registers the sign-corrected or saturated result, pulses done and returns to `ST_IDLE`.

Top module: `iter_divider`

## Requirements
- R1: With `unsigned_i`=1, the quotient is the unsigned integer quotient of `dividend_i` by `divisor_i`.
- R2: With `unsigned_i`=0, both operands are two's complement and the quotient truncates toward zero (for example 0xFFFFFFF9 / 2 gives 0xFFFFFFFD).
- R3: A zero divisor gives `quot_o`=0 and sets `fault_o`, with `done_o` high in the cycle right after the accepting edge.
- R4: With `unsigned_i`=0, dividend 0x80000000 and divisor 0xFFFFFFFF, the result is 0x80000000 and `fault_o` is set. In unsigned mode the same operands give 0 and no fault.
- R5: On a fault with `exc_en_i`=1, `exc_req_o` pulses together with `done_o`. `exc_cause_o` is 5'b00101, and `exc_detail_o` is 0 for a zero divisor and 1 for overflow. With `exc_en_i`=0, `exc_req_o` stays low.
- R6: `wr_en_o` pulses with `done_o`, except on a fault with exceptions enabled, where it stays low.
- R7: For a non-zero divisor, `done_o` rises after the (WIDTH+2)-th rising edge, counting the accepting edge as the first. That is 34 edges for WIDTH=32. With `AREA_OPT`=1 it rises after the (WIDTH+3)-th edge.
- R8: `fault_o` stays set until `fault_clr_i` is sampled high. A fault that finishes at the same edge as a clear leaves the flag set.
- R9: `busy_o` is high from the accepting edge until the finishing edge. A start sampled while `busy_o` is high is ignored.
- R10: `done_o` is high for exactly one cycle per operation, and `quot_o` holds its value until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe; sampled only while idle |
| unsigned_i | input | 1 | 1: unsigned operands, 0: signed |
| exc_en_i | input | 1 | Enables the exception request on a fault |
| dividend_i | input | WIDTH | Dividend operand |
| divisor_i | input | WIDTH | Divisor operand |
| fault_clr_i | input | 1 | Clears the sticky fault flag |
| quot_o | output | WIDTH | Quotient, held until the next completion |
| done_o | output | 1 | One-cycle completion strobe |
| wr_en_o | output | 1 | Destination write enable, pulses with done |
| busy_o | output | 1 | Operation in flight |
| fault_o | output | 1 | Sticky divide-fault flag |
| exc_req_o | output | 1 | Exception request, pulses with done |
| exc_cause_o | output | 5 | Exception cause code |
| exc_detail_o | output | 1 | 0: zero divisor, 1: signed overflow |

## Verification
The assertions treat a start as meaningful only when `busy_o` is low. They count the latency window from that qualified start, and they assume the inputs are known and stable around each rising edge. The stimulus drives all inputs on the falling edge. It also issues starts on purpose while an operation is in flight, and in the very cycle done is high, so that both the drop rule and back-to-back acceptance are exercised while the assumptions still hold.

// File: rtl/iter_div_pkg.sv
package iter_div_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ITER,
        ST_PAD,
        ST_FIXUP
    } div_state_e;

    localparam logic [4:0] DIV_FAULT_CAUSE = 5'b00101;

    typedef struct packed {
        logic by_zero;
        logic overflow;
        logic neg_result;
    } div_class_t;

endpackage

// File: rtl/div_classify.sv
module div_classify
    import iter_div_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] dividend_i,
    input  logic [WIDTH-1:0] divisor_i,
    input  logic             unsigned_i,
    output div_class_t       cls_o,
    output logic [WIDTH-1:0] mag_dividend_o,
    output logic [WIDTH-1:0] mag_divisor_o
);
    localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};
    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

    logic neg_dvd;
    logic neg_dvs;

    always_comb begin
        neg_dvd        = !unsigned_i && dividend_i[WIDTH-1];
        neg_dvs        = !unsigned_i && divisor_i[WIDTH-1];
        mag_dividend_o = neg_dvd ? (~dividend_i + 1'b1) : dividend_i;
        mag_divisor_o  = neg_dvs ? (~divisor_i + 1'b1) : divisor_i;
        cls_o.by_zero    = (divisor_i == '0);
        cls_o.overflow   = !unsigned_i && (dividend_i == MOST_NEG) && (divisor_i == ALL_ONES);
        cls_o.neg_result = neg_dvd ^ neg_dvs;
    end

endmodule

// File: rtl/div_shift_sub.sv
module div_shift_sub #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             step_i,
    input  logic [WIDTH-1:0] dividend_i,
    input  logic [WIDTH-1:0] divisor_i,
    output logic [WIDTH-1:0] quot_o
);
    logic [WIDTH-1:0] rem_q;
    logic [WIDTH-1:0] acc_q;
    logic [WIDTH-1:0] dvs_q;
    logic [WIDTH:0]   partial;
    logic [WIDTH:0]   diff;
    logic             fits;

    always_comb begin
        partial = {rem_q, acc_q[WIDTH-1]};
        diff    = partial - {1'b0, dvs_q};
        fits    = (partial >= {1'b0, dvs_q});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
            acc_q <= '0;
            dvs_q <= '0;
        end else if (load_i) begin
            rem_q <= '0;
            acc_q <= dividend_i;
            dvs_q <= divisor_i;
        end else if (step_i) begin
            rem_q <= fits ? diff[WIDTH-1:0] : partial[WIDTH-1:0];
            acc_q <= {acc_q[WIDTH-2:0], fits};
        end
    end

    assign quot_o = acc_q;

endmodule

// File: rtl/div_sign_restore.sv
module div_sign_restore #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] mag_i,
    input  logic             negate_i,
    output logic [WIDTH-1:0] value_o
);
    always_comb begin
        value_o = negate_i ? (~mag_i + 1'b1) : mag_i;
    end

endmodule

// File: rtl/iter_divider.sv
module iter_divider
    import iter_div_pkg::*;
#(
    parameter int WIDTH    = 32,
    parameter bit AREA_OPT = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             unsigned_i,
    input  logic             exc_en_i,
    input  logic [WIDTH-1:0] dividend_i,
    input  logic [WIDTH-1:0] divisor_i,
    input  logic             fault_clr_i,
    output logic [WIDTH-1:0] quot_o,
    output logic             done_o,
    output logic             wr_en_o,
    output logic             busy_o,
    output logic             fault_o,
    output logic             exc_req_o,
    output logic [4:0]       exc_cause_o,
    output logic             exc_detail_o
);
    localparam int               CNT_W    = $clog2(WIDTH);
    localparam logic [CNT_W-1:0] LAST_IT  = CNT_W'(WIDTH - 1);
    localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};

    div_state_e       state_q, state_d;
    logic [CNT_W-1:0] iter_q;
    logic             ovf_q;
    logic             neg_q;
    logic             exc_en_q;

    div_class_t       cls;
    logic [WIDTH-1:0] mag_dvd, mag_dvs;
    logic [WIDTH-1:0] raw_quot, signed_quot;

    logic             accept;
    logic             fin_zero, fin_norm, fin_any;
    logic             fin_fault, fin_exc_en;
    logic [WIDTH-1:0] fin_value;

    div_classify #(.WIDTH(WIDTH)) u_classify (
        .dividend_i     (dividend_i),
        .divisor_i      (divisor_i),
        .unsigned_i     (unsigned_i),
        .cls_o          (cls),
        .mag_dividend_o (mag_dvd),
        .mag_divisor_o  (mag_dvs)
    );

    div_shift_sub #(.WIDTH(WIDTH)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (accept && !cls.by_zero),
        .step_i     (state_q == ST_ITER),
        .dividend_i (mag_dvd),
        .divisor_i  (mag_dvs),
        .quot_o     (raw_quot)
    );

    div_sign_restore #(.WIDTH(WIDTH)) u_sign (
        .mag_i    (raw_quot),
        .negate_i (neg_q),
        .value_o  (signed_quot)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i && !cls.by_zero) state_d = ST_ITER;
            ST_ITER:  if (iter_q == LAST_IT) state_d = AREA_OPT ? ST_PAD : ST_FIXUP;
            ST_PAD:   state_d = ST_FIXUP;
            ST_FIXUP: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Iteration counter and captured operand class
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            iter_q   <= '0;
            ovf_q    <= 1'b0;
            neg_q    <= 1'b0;
            exc_en_q <= 1'b0;
        end else if (accept) begin
            iter_q   <= '0;
            ovf_q    <= cls.overflow;
            neg_q    <= cls.neg_result;
            exc_en_q <= exc_en_i;
        end else if (state_q == ST_ITER) begin
            iter_q <= iter_q + 1'b1;
        end
    end

    // Completion decode
    always_comb begin
        accept     = (state_q == ST_IDLE) && start_i;
        fin_zero   = accept && cls.by_zero;
        fin_norm   = (state_q == ST_FIXUP);
        fin_any    = fin_zero || fin_norm;
        fin_fault  = fin_zero || (fin_norm && ovf_q);
        fin_exc_en = fin_zero ? exc_en_i : exc_en_q;
        if (fin_zero)   fin_value = '0;
        else if (ovf_q) fin_value = MOST_NEG;
        else            fin_value = signed_quot;
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quot_o       <= '0;
            done_o       <= 1'b0;
            wr_en_o      <= 1'b0;
            fault_o      <= 1'b0;
            exc_req_o    <= 1'b0;
            exc_cause_o  <= '0;
            exc_detail_o <= 1'b0;
        end else begin
            done_o    <= fin_any;
            wr_en_o   <= fin_any && !(fin_fault && fin_exc_en);
            exc_req_o <= fin_fault && fin_exc_en;
            if (fin_any) quot_o <= fin_value;
            if (fin_fault) begin
                fault_o      <= 1'b1;
                exc_cause_o  <= DIV_FAULT_CAUSE;
                exc_detail_o <= !fin_zero;
            end else if (fault_clr_i) begin
                fault_o <= 1'b0;
            end
        end
    end

    assign busy_o = (state_q != ST_IDLE);

endmodule

// File: rtl/iter_divider_chk.sv
module iter_divider_chk #(
    parameter int WIDTH    = 32,
    parameter bit AREA_OPT = 1'b0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [WIDTH-1:0] divisor_i,
    input logic             fault_clr_i,
    input logic [WIDTH-1:0] quot_o,
    input logic             done_o,
    input logic             wr_en_o,
    input logic             busy_o,
    input logic             fault_o,
    input logic             exc_req_o,
    input logic [4:0]       exc_cause_o
);
    localparam int LAT   = WIDTH + 2 + (AREA_OPT ? 1 : 0);
    localparam int LCW   = $clog2(LAT + 1) + 1;

    logic [LCW-1:0] lat_cnt;
    logic           lat_act;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_cnt <= '0;
            lat_act <= 1'b0;
        end else if (start_i && !busy_o && divisor_i != '0) begin
            lat_cnt <= LCW'(1);
            lat_act <= 1'b1;
        end else if (lat_act) begin
            if (done_o) lat_act <= 1'b0;
            else        lat_cnt <= lat_cnt + 1'b1;
        end
    end

    AST_LATENCY_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        lat_act && done_o |-> lat_cnt == LCW'(LAT)); // R7
    AST_NO_EARLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        lat_act && (lat_cnt < LCW'(LAT)) |-> !done_o); // R7
    AST_ZERO_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !busy_o && divisor_i == '0 |=> done_o && quot_o == '0 && fault_o); // R3
    AST_CAUSE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req_o |-> exc_cause_o == 5'b00101 && done_o); // R5
    AST_EXC_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req_o |-> !wr_en_o); // R6
    AST_WRITE_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> done_o); // R6
    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o && !fault_clr_i |=> fault_o); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !(start_i && divisor_i == '0) |=> !done_o); // R10
    AST_QUOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o && $past(!done_o) |-> $stable(quot_o)); // R10

endmodule

bind iter_divider iter_divider_chk #(.WIDTH(WIDTH), .AREA_OPT(AREA_OPT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .divisor_i   (divisor_i),
    .fault_clr_i (fault_clr_i),
    .quot_o      (quot_o),
    .done_o      (done_o),
    .wr_en_o     (wr_en_o),
    .busy_o      (busy_o),
    .fault_o     (fault_o),
    .exc_req_o   (exc_req_o),
    .exc_cause_o (exc_cause_o)
);

// File: tb/tb_iter_divider.sv
`timescale 1ns/1ps
module tb_iter_divider;
    localparam int LAT = 34;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, unsigned_i = 1'b0, exc_en_i = 1'b0, fault_clr_i = 1'b0;
    logic [31:0] dividend_i = '0, divisor_i = '0;
    logic [31:0] quot_o;
    logic        done_o, wr_en_o, busy_o, fault_o, exc_req_o, exc_detail_o;
    logic [4:0]  exc_cause_o;

    always #2 clk = ~clk;

    iter_divider dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .unsigned_i(unsigned_i),
        .exc_en_i(exc_en_i), .dividend_i(dividend_i), .divisor_i(divisor_i),
        .fault_clr_i(fault_clr_i), .quot_o(quot_o), .done_o(done_o),
        .wr_en_o(wr_en_o), .busy_o(busy_o), .fault_o(fault_o),
        .exc_req_o(exc_req_o), .exc_cause_o(exc_cause_o), .exc_detail_o(exc_detail_o)
    );

    // Behavioural reference model state
    logic [31:0] m_q = '0, m_pend = '0;
    logic        m_done = 0, m_wr = 0, m_busy = 0, m_fault = 0, m_exc = 0, m_det = 0;
    logic        m_pend_ovf = 0, m_pend_en = 0;
    logic [4:0]  m_cause = '0;
    int          m_left = 0;
    string       m_tag = "R1";
    longint      sa, sb, sq;
    int          n_cmp = 0, n_bad = 0, cycles = 0;

    function automatic void finish_op(logic [31:0] res, logic flt, logic det, logic en);
        m_done = 1; m_q = res;
        if (flt) begin
            m_fault = 1; m_cause = 5'b00101; m_det = det; m_exc = en; m_wr = !en;
        end else m_wr = 1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_q = '0; m_done = 0; m_wr = 0; m_busy = 0; m_fault = 0; m_exc = 0;
            m_det = 0; m_cause = '0; m_left = 0;
        end else begin
            m_done = 0; m_wr = 0; m_exc = 0;
            if (fault_clr_i) m_fault = 0;
            if (m_busy) begin
                m_left--;
                if (m_left == 0) begin
                    m_busy = 0;
                    finish_op(m_pend, m_pend_ovf, 1'b1, m_pend_en);
                end
            end else if (start_i) begin
                if (divisor_i == 0) begin
                    m_tag = "R3";
                    finish_op(32'h0, 1'b1, 1'b0, exc_en_i);
                end else begin
                    m_busy = 1; m_left = LAT - 1; m_pend_en = exc_en_i;
                    if (unsigned_i) begin
                        m_tag = "R1"; m_pend_ovf = 0; m_pend = dividend_i / divisor_i;
                    end else begin
                        sa = longint'($signed(divisor_i));
                        sb = longint'($signed(dividend_i));
                        sq = sb / sa;
                        m_pend = sq[31:0];
                        m_pend_ovf = (dividend_i == 32'h80000000) && (divisor_i == 32'hFFFFFFFF);
                        m_tag = m_pend_ovf ? "R4" : "R2";
                    end
                end
            end
        end
    end

    task automatic cmp(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare every cycle on the falling edge
    always @(negedge clk) begin
        cmp("R9", "busy", 32'(busy_o), 32'(m_busy));
        cmp("R7", "done", 32'(done_o), 32'(m_done));
        cmp("R6", "wr_en", 32'(wr_en_o), 32'(m_wr));
        cmp("R8", "fault", 32'(fault_o), 32'(m_fault));
        cmp("R5", "exc_req", 32'(exc_req_o), 32'(m_exc));
        cmp(m_done ? m_tag : "R10", "quot", quot_o, m_q);
        if (m_exc) begin
            cmp("R5", "cause", 32'(exc_cause_o), 32'(m_cause));
            cmp("R5", "detail", 32'(exc_detail_o), 32'(m_det));
        end
    end

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 100000) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    task automatic issue(logic [31:0] dvd, logic [31:0] dvs, logic uns, logic en);
        @(negedge clk);
        start_i = 1; dividend_i = dvd; divisor_i = dvs; unsigned_i = uns; exc_en_i = en;
        @(negedge clk);
        start_i = 0;
    endtask

    task automatic wait_idle();
        while (m_busy) @(negedge clk);
    endtask

    task automatic run(logic [31:0] dvd, logic [31:0] dvs, logic uns, logic en);
        issue(dvd, dvs, uns, en);
        wait_idle();
        @(negedge clk);
    endtask

    task automatic clear_fault();
        @(negedge clk); fault_clr_i = 1;
        @(negedge clk); fault_clr_i = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 unsigned
        run(32'd100, 32'd7, 1, 0);
        run(32'hFFFFFFFF, 32'd1, 1, 0);
        run(32'hFFFFFFFF, 32'h10, 1, 1);
        // R2 signed, truncation toward zero
        run(32'hFFFFFFF9, 32'd2, 0, 0);
        run(32'd7, 32'hFFFFFFFE, 0, 0);
        run(32'hFFFFFFF9, 32'hFFFFFFFE, 0, 1);
        // R4 overflow, exceptions off then on; unsigned same operands
        run(32'h80000000, 32'hFFFFFFFF, 0, 0);
        clear_fault();
        run(32'h80000000, 32'hFFFFFFFF, 0, 1);
        run(32'h80000000, 32'hFFFFFFFF, 1, 1);
        clear_fault();
        // R3 zero divisor, R5 detail 0, R6 write suppressed
        run(32'd55, 32'd0, 0, 0);
        clear_fault();
        run(32'd55, 32'd0, 1, 1);
        // R8 fault then clear in same cycle as a new zero fault: set wins
        @(negedge clk);
        start_i = 1; divisor_i = 0; fault_clr_i = 1;
        @(negedge clk);
        start_i = 0; fault_clr_i = 0;
        clear_fault();
        // R9 start while busy is ignored
        issue(32'd1000, 32'd10, 1, 0);
        repeat (5) @(negedge clk);
        start_i = 1; dividend_i = 32'd9; divisor_i = 32'd0;
        @(negedge clk);
        start_i = 0;
        wait_idle();
        // Back-to-back: start in the done cycle (R10)
        start_i = 1; dividend_i = 32'd81; divisor_i = 32'd9; unsigned_i = 0;
        @(negedge clk);
        start_i = 0;
        wait_idle();
        for (int i = 0; i < 24; i++) begin
            logic [31:0] a, b;
            a = $urandom();
            b = (i % 3 == 0) ? ($urandom() % 17) : $urandom();
            if (i % 5 == 0) b = 32'hFFFFFFFF;
            issue(a, b, 1'(i % 2), 1'(i % 4 == 1));
            wait_idle();
            if (i % 6 == 0) clear_fault();
        end
        repeat (3) @(negedge clk);
        summary();
        $finish;
    end

endmodule